// File: doc/BRIEF.md
# Redundant Reference Source Voter

This block merges three redundant attitude/air-data reference channels into one value for the flight control laws. Sources 0 and 1 are the primary channels wired straight to this unit; source 2 is the backup that reaches it through the neighbouring unit. Each source presents a signed data word, a validity flag (the result of bus-level checks done elsewhere) and a mode bit that says whether the source is in full navigation mode or in a reduced attitude-only mode.

On each sample strobe the block votes the sources. With healthy navigation sources it averages a pair: the two primaries when all three are usable, otherwise the remaining two. Attitude-only sources are excluded while any navigation source is alive. When none is in navigation mode, a single attitude-only source is passed through and a degraded flag tells the laws to fall back. A three-way comparator with a programmable threshold and persistence count latches a source that disagrees with both others. When only two sources remain, their disagreement raises an alarm instead.

Top module: `refsel_top`

## Requirements
- R1: After reset the output value is 0, all failed flags are 0, the degraded and alarm flags are 0, and the output-invalid flag is 1.
- R2: Outputs change only at a rising clock edge where `sample_i` is 1, and they show the result for the inputs present at that edge; without a strobe they hold.
- R3: Bit i of `src_nav_i` is 1 for navigation mode and 0 for attitude-only. When all three sources are usable in navigation mode, the value is floor((s0 + s1) / 2), computed without overflow.
- R4: When exactly two navigation sources are usable, the value is floor of half the sum of those two.
- R5: While at least one valid, non-latched source reports navigation mode, every source reporting attitude-only mode is flagged failed and is not used.
- R6: When exactly one navigation source is usable, the value equals that source and the degraded flag is 0.
- R7: When no valid, non-latched source is in navigation mode, the lowest-index valid, non-latched source (necessarily attitude-only) is passed through and the degraded flag is 1.
- R8: When no source is usable, the output-invalid flag is 1, the value is 0 and the degraded flag is 0.
- R9: While all three sources are valid and none is latched, a source whose absolute difference to each of the other two exceeds `cfg_thresh_i` for `cfg_persist_i` consecutive strobes (0 acts as 1) is latched failed. The latch already counts in the output of that strobe. A non-disagreeing strobe restarts the count.
- R10: A latched failure stays set until reset, whatever the later data or validity.
- R11: When exactly two navigation sources are usable and their absolute difference exceeds `cfg_thresh_i`, the alarm flag is 1 and the value is still their half-sum; otherwise the alarm is 0.
- R12: Failed bit i is 1 exactly when source i is invalid, latched (R9), or excluded by R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_i | input | 1 | Sample strobe |
| src_data_i | input | 3*DW | Signed data of sources 0..2, source 0 in the low bits |
| src_valid_i | input | 3 | Per-source validity |
| src_nav_i | input | 3 | Per-source mode, 1 = navigation, 0 = attitude-only |
| cfg_thresh_i | input | DW | Unsigned disagreement threshold |
| cfg_persist_i | input | CW | Consecutive disagreeing strobes needed to latch |
| sel_value_o | output | DW | Voted signed value |
| src_failed_o | output | 3 | Per-source failed flags |
| degraded_o | output | 1 | Single attitude-only source in use |
| out_invalid_o | output | 1 | No usable source |
| cmp_alarm_o | output | 1 | Remaining pair disagrees |

## Verification
The assertions check on every cycle that the outputs hold between strobes, that a latched failure never clears, and that a latched source always shows as failed. They also check that no attitude-only source stays unflagged while a navigation source is alive, and that an invalid output carries a zero value with the degraded and alarm flags low. The arithmetic of the half-sum, the choice of pair or single source, and the persistence count (including its restart on an agreeing strobe) can only be shown by the bench's scenarios. The bench compares these against values it computes itself.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

    localparam int NSRC = 3;

    typedef enum logic [1:0] {
        M_NONE   = 2'd0,
        M_PAIR   = 2'd1,
        M_SINGLE = 2'd2,
        M_ATT    = 2'd3
    } sel_mode_t;

    typedef struct packed {
        sel_mode_t  mode;
        logic [1:0] ia;
        logic [1:0] ib;
        logic       dual;
    } sel_plan_t;

    typedef struct packed {
        logic [NSRC-1:0] failed;
        logic            degraded;
        logic            invalid;
        logic            alarm;
    } sel_flags_t;

endpackage

// File: rtl/refsel_cmp.sv
module refsel_cmp #(
    parameter int DW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sample_i,
    input  logic          elig_i,
    input  logic [DW-1:0] self_i,
    input  logic [DW-1:0] peer_a_i,
    input  logic [DW-1:0] peer_b_i,
    input  logic [DW-1:0] thresh_i,
    input  logic [CW-1:0] persist_i,
    output logic          lat_q_o,
    output logic          lat_n_o
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;
    logic          dis;
    logic          trip;

    function automatic logic [DW:0] adiff(input logic [DW-1:0] a, input logic [DW-1:0] b);
        logic signed [DW:0] x;
        x = $signed({a[DW-1], a}) - $signed({b[DW-1], b});
        return x[DW] ? (-x) : x;
    endfunction

    always_comb begin
        lim  = (persist_i == '0) ? CW'(1) : persist_i;
        dis  = elig_i && (adiff(self_i, peer_a_i) > {1'b0, thresh_i})
                      && (adiff(self_i, peer_b_i) > {1'b0, thresh_i});
        trip = sample_i && dis && (({1'b0, cnt_q} + (CW+1)'(1)) >= {1'b0, lim});
        lat_n_o = lat_q_o | trip;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            lat_q_o <= 1'b0;
        end else begin
            lat_q_o <= lat_n_o;
            if (sample_i) begin
                if (!dis)
                    cnt_q <= '0;
                else if (cnt_q != CNT_MAX)
                    cnt_q <= cnt_q + CW'(1);
            end
        end
    end

endmodule

// File: rtl/refsel_pick.sv
module refsel_pick
    import refsel_pkg::*;
(
    input  logic [NSRC-1:0] valid_i,
    input  logic [NSRC-1:0] nav_i,
    input  logic [NSRC-1:0] lat_i,
    output sel_plan_t       plan_o,
    output logic [NSRC-1:0] failed_o
);
    logic [NSRC-1:0] live;
    logic [NSRC-1:0] navok;
    logic            any_nav;

    always_comb begin
        live     = valid_i & ~lat_i;
        navok    = live & nav_i;
        any_nav  = |navok;
        failed_o = ~valid_i | lat_i | (any_nav ? ~nav_i : '0);
        plan_o   = '{mode: M_NONE, ia: 2'd0, ib: 2'd0, dual: 1'b0};
        if (any_nav) begin
            case (navok)
                3'b111: plan_o = '{mode: M_PAIR,   ia: 2'd0, ib: 2'd1, dual: 1'b0};
                3'b011: plan_o = '{mode: M_PAIR,   ia: 2'd0, ib: 2'd1, dual: 1'b1};
                3'b101: plan_o = '{mode: M_PAIR,   ia: 2'd0, ib: 2'd2, dual: 1'b1};
                3'b110: plan_o = '{mode: M_PAIR,   ia: 2'd1, ib: 2'd2, dual: 1'b1};
                3'b001: plan_o = '{mode: M_SINGLE, ia: 2'd0, ib: 2'd0, dual: 1'b0};
                3'b010: plan_o = '{mode: M_SINGLE, ia: 2'd1, ib: 2'd1, dual: 1'b0};
                default: plan_o = '{mode: M_SINGLE, ia: 2'd2, ib: 2'd2, dual: 1'b0};
            endcase
        end else if (live[0]) begin
            plan_o = '{mode: M_ATT, ia: 2'd0, ib: 2'd0, dual: 1'b0};
        end else if (live[1]) begin
            plan_o = '{mode: M_ATT, ia: 2'd1, ib: 2'd1, dual: 1'b0};
        end else if (live[2]) begin
            plan_o = '{mode: M_ATT, ia: 2'd2, ib: 2'd2, dual: 1'b0};
        end
    end

endmodule

// File: rtl/refsel_top.sv
module refsel_top
    import refsel_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sample_i,
    input  logic [3*DW-1:0]    src_data_i,
    input  logic [2:0]         src_valid_i,
    input  logic [2:0]         src_nav_i,
    input  logic [DW-1:0]      cfg_thresh_i,
    input  logic [CW-1:0]      cfg_persist_i,
    output logic [DW-1:0]      sel_value_o,
    output logic [2:0]         src_failed_o,
    output logic               degraded_o,
    output logic               out_invalid_o,
    output logic               cmp_alarm_o
);
    logic [NSRC-1:0][DW-1:0] dv;
    logic [NSRC-1:0]         lat_q;
    logic [NSRC-1:0]         lat_n;
    logic                    elig;
    sel_plan_t               plan;
    logic [NSRC-1:0]         fail_c;
    logic [DW-1:0]           val_c;
    sel_flags_t              flg_c;

    assign dv   = src_data_i;
    assign elig = (src_valid_i == '1) && (lat_q == '0);

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_cmp
            refsel_cmp #(.DW(DW), .CW(CW)) u_cmp (
                .clk       (clk),
                .rst       (rst),
                .sample_i  (sample_i),
                .elig_i    (elig),
                .self_i    (dv[i]),
                .peer_a_i  (dv[(i+1)%NSRC]),
                .peer_b_i  (dv[(i+2)%NSRC]),
                .thresh_i  (cfg_thresh_i),
                .persist_i (cfg_persist_i),
                .lat_q_o   (lat_q[i]),
                .lat_n_o   (lat_n[i])
            );
        end
    endgenerate

    refsel_pick u_pick (
        .valid_i  (src_valid_i),
        .nav_i    (src_nav_i),
        .lat_i    (lat_n),
        .plan_o   (plan),
        .failed_o (fail_c)
    );

    function automatic logic [DW-1:0] src_at(input logic [1:0] idx, input logic [NSRC-1:0][DW-1:0] d);
        case (idx)
            2'd0:    return d[0];
            2'd1:    return d[1];
            default: return d[2];
        endcase
    endfunction

    function automatic logic [DW-1:0] half_sum(input logic [DW-1:0] a, input logic [DW-1:0] b);
        logic signed [DW:0] s;
        logic signed [DW:0] h;
        s = $signed({a[DW-1], a}) + $signed({b[DW-1], b});
        h = s >>> 1;
        return h[DW-1:0];
    endfunction

    function automatic logic [DW:0] adiff(input logic [DW-1:0] a, input logic [DW-1:0] b);
        logic signed [DW:0] x;
        x = $signed({a[DW-1], a}) - $signed({b[DW-1], b});
        return x[DW] ? (-x) : x;
    endfunction

    always_comb begin
        logic [DW-1:0] va;
        logic [DW-1:0] vb;
        va = src_at(plan.ia, dv);
        vb = src_at(plan.ib, dv);
        flg_c = '{failed: fail_c, degraded: 1'b0, invalid: 1'b0, alarm: 1'b0};
        val_c = '0;
        case (plan.mode)
            M_PAIR: begin
                val_c       = half_sum(va, vb);
                flg_c.alarm = plan.dual && (adiff(va, vb) > {1'b0, cfg_thresh_i});
            end
            M_SINGLE: val_c = va;
            M_ATT: begin
                val_c          = va;
                flg_c.degraded = 1'b1;
            end
            default: flg_c.invalid = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_value_o   <= '0;
            src_failed_o  <= '0;
            degraded_o    <= 1'b0;
            out_invalid_o <= 1'b1;
            cmp_alarm_o   <= 1'b0;
        end else if (sample_i) begin
            sel_value_o   <= val_c;
            src_failed_o  <= flg_c.failed;
            degraded_o    <= flg_c.degraded;
            out_invalid_o <= flg_c.invalid;
            cmp_alarm_o   <= flg_c.alarm;
        end
    end

endmodule

// File: rtl/refsel_chk.sv
module refsel_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          sample_i,
    input logic [2:0]    src_valid_i,
    input logic [2:0]    src_nav_i,
    input logic [2:0]    lat_q,
    input logic [2:0]    lat_n,
    input logic [DW-1:0] sel_value_o,
    input logic [2:0]    src_failed_o,
    input logic          degraded_o,
    input logic          out_invalid_o,
    input logic          cmp_alarm_o
);
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !sample_i |=> $stable(sel_value_o) && $stable(src_failed_o)
                      && $stable(degraded_o) && $stable(out_invalid_o) && $stable(cmp_alarm_o));

    p_nav_excl_r5: assert property (@(posedge clk) disable iff (rst)
        (sample_i && ((src_valid_i & src_nav_i & ~lat_n) != 3'b000))
        |=> !degraded_o && ((~src_failed_o & ~$past(src_nav_i)) == 3'b000));

    p_att_ok_r7: assert property (@(posedge clk) disable iff (rst)
        degraded_o |-> !out_invalid_o && !cmp_alarm_o);

    p_none_r8: assert property (@(posedge clk) disable iff (rst)
        out_invalid_o |-> (sel_value_o == '0) && !degraded_o && !cmp_alarm_o);

    p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((lat_q & $past(lat_q)) == $past(lat_q)));

    p_latched_failed_r12: assert property (@(posedge clk) disable iff (rst)
        sample_i |=> ((src_failed_o & $past(lat_n)) == $past(lat_n)));

endmodule

bind refsel_top refsel_chk #(.DW(DW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .sample_i      (sample_i),
    .src_valid_i   (src_valid_i),
    .src_nav_i     (src_nav_i),
    .lat_q         (lat_q),
    .lat_n         (lat_n),
    .sel_value_o   (sel_value_o),
    .src_failed_o  (src_failed_o),
    .degraded_o    (degraded_o),
    .out_invalid_o (out_invalid_o),
    .cmp_alarm_o   (cmp_alarm_o)
);

// File: tb/tb_refsel_top.sv
module tb_refsel_top;
    localparam int DW = 8;
    localparam int CW = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            sample_i = 1'b0;
    logic [3*DW-1:0] src_data_i = '0;
    logic [2:0]      src_valid_i = '0;
    logic [2:0]      src_nav_i = '0;
    logic [DW-1:0]   cfg_thresh_i = '1;
    logic [CW-1:0]   cfg_persist_i = 4'd1;
    logic [DW-1:0]   sel_value_o;
    logic [2:0]      src_failed_o;
    logic            degraded_o;
    logic            out_invalid_o;
    logic            cmp_alarm_o;

    refsel_top #(.DW(DW), .CW(CW)) dut (.*);

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    bit [2:0] m_lat;
    int       m_cnt [3];
    int       e_val;
    bit [2:0] e_fail;
    bit       e_deg, e_inv, e_alm;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int iabs(input int x);
        return (x < 0) ? -x : x;
    endfunction

    task automatic model(input int d0, input int d1, input int d2, input bit [2:0] v, input bit [2:0] n);
        int d[3];
        bit elig;
        bit dis [3];
        int lim;
        bit [2:0] live, navok;
        int cntn;
        d[0] = d0; d[1] = d1; d[2] = d2;
        lim  = (cfg_persist_i == 0) ? 1 : int'(cfg_persist_i);
        elig = (v == 3'b111) && (m_lat == 3'b000);
        for (int i = 0; i < 3; i++)
            dis[i] = elig && iabs(d[i]-d[(i+1)%3]) > int'(cfg_thresh_i)
                          && iabs(d[i]-d[(i+2)%3]) > int'(cfg_thresh_i);
        for (int i = 0; i < 3; i++) begin
            if (dis[i]) begin
                m_cnt[i]++;
                if (m_cnt[i] >= lim) m_lat[i] = 1'b1;
            end else m_cnt[i] = 0;
        end
        live  = v & ~m_lat;
        navok = live & n;
        e_fail = ~v | m_lat | ((navok != 0) ? ~n : 3'b000);
        e_deg = 0; e_inv = 0; e_alm = 0; e_val = 0;
        cntn = int'(navok[0]) + int'(navok[1]) + int'(navok[2]);
        if (cntn == 3) e_val = (d[0] + d[1]) >>> 1;
        else if (cntn == 2) begin
            int a, b, k;
            k = 0; a = 0; b = 0;
            for (int i = 0; i < 3; i++)
                if (navok[i]) begin
                    if (k == 0) a = d[i]; else b = d[i];
                    k++;
                end
            e_val = (a + b) >>> 1;
            e_alm = iabs(a - b) > int'(cfg_thresh_i);
        end else if (cntn == 1) begin
            for (int i = 0; i < 3; i++) if (navok[i]) e_val = d[i];
        end else if (live != 0) begin
            e_deg = 1;
            for (int i = 2; i >= 0; i--) if (live[i]) e_val = d[i];
        end else e_inv = 1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        sample_i = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_lat = '0;
        for (int i = 0; i < 3; i++) m_cnt[i] = 0;
    endtask

    task automatic check_out(input string req);
        chk($signed(sel_value_o) == e_val, req, "value", $signed(sel_value_o), e_val);
        chk(src_failed_o == e_fail, "R12", "failed", src_failed_o, e_fail);
        chk(degraded_o == e_deg, req, "degraded", degraded_o, e_deg);
        chk(out_invalid_o == e_inv, "R8", "invalid", out_invalid_o, e_inv);
        chk(cmp_alarm_o == e_alm, "R11", "alarm", cmp_alarm_o, e_alm);
    endtask

    task automatic step(input int d0, input int d1, input int d2, input bit [2:0] v, input bit [2:0] n, input string req);
        @(negedge clk);
        src_data_i  = {d2[DW-1:0], d1[DW-1:0], d0[DW-1:0]};
        src_valid_i = v;
        src_nav_i   = n;
        sample_i    = 1'b1;
        model(d0, d1, d2, v, n);
        @(negedge clk);
        sample_i = 1'b0;
        check_out(req);
    endtask

    initial begin
        int ds [4][3];
        ds[0] = '{0, 2, -6};
        ds[1] = '{127, 127, -128};
        ds[2] = '{-128, -128, 5};
        ds[3] = '{-3, -4, 100};

        do_reset();
        // R1: reset state
        chk(sel_value_o == 0, "R1", "value", sel_value_o, 0);
        chk(src_failed_o == 0, "R1", "failed", src_failed_o, 0);
        chk(degraded_o == 0, "R1", "degraded", degraded_o, 0);
        chk(out_invalid_o == 1, "R1", "invalid", out_invalid_o, 1);
        chk(cmp_alarm_o == 0, "R1", "alarm", cmp_alarm_o, 0);

        // R3 R4 R5 R6 R7 R8: sweep of validity x mode x data, comparator disabled
        cfg_thresh_i = 8'd255;
        cfg_persist_i = 4'd1;
        for (int s = 0; s < 4; s++)
            for (int v = 0; v < 8; v++)
                for (int n = 0; n < 8; n++)
                    step(ds[s][0], ds[s][1], ds[s][2], 3'(v), 3'(n), "R3_R4_R5_R6_R7");

        // R2: outputs hold without a strobe
        step(10, 20, 30, 3'b111, 3'b111, "R3");
        @(negedge clk);
        src_data_i = {8'd1, 8'd1, 8'd1};
        src_valid_i = 3'b000;
        repeat (3) @(negedge clk);
        chk($signed(sel_value_o) == 15, "R2", "held value", $signed(sel_value_o), 15);
        chk(out_invalid_o == 0, "R2", "held invalid", out_invalid_o, 0);

        // R9: persistence, restart on agreement, then latch
        do_reset();
        cfg_thresh_i = 8'd10;
        cfg_persist_i = 4'd3;
        step(0, 2, 50, 3'b111, 3'b111, "R9");
        step(0, 2, 50, 3'b111, 3'b111, "R9");
        step(0, 2, 5, 3'b111, 3'b111, "R9");
        step(0, 2, 50, 3'b111, 3'b111, "R9");
        step(0, 2, 50, 3'b111, 3'b111, "R9");
        chk(src_failed_o == 3'b000, "R9", "no early latch", src_failed_o, 0);
        step(0, 2, 50, 3'b111, 3'b111, "R9");
        chk(src_failed_o == 3'b100, "R9", "latched", src_failed_o, 3'b100);
        // R10: stays latched on agreeing data
        step(0, 2, 1, 3'b111, 3'b111, "R10");
        chk(src_failed_o[2] == 1, "R10", "sticky", src_failed_o[2], 1);
        // R11: remaining pair disagrees
        step(0, 40, 1, 3'b111, 3'b111, "R11");
        chk(cmp_alarm_o == 1, "R11", "pair alarm", cmp_alarm_o, 1);
        // R6 after latch: single remaining
        step(0, 7, 1, 3'b110, 3'b111, "R6");
        chk($signed(sel_value_o) == 7, "R6", "single", $signed(sel_value_o), 7);
        // R7 with latch: only latched source nav
        step(-9, 7, 1, 3'b111, 3'b100, "R7");
        chk(degraded_o == 1, "R7", "degraded", degraded_o, 1);

        // R9: persist 0 acts as 1, primary source latched
        do_reset();
        cfg_persist_i = 4'd0;
        step(-100, 2, 4, 3'b111, 3'b111, "R9");
        chk(src_failed_o == 3'b001, "R9", "persist0", src_failed_o, 1);
        step(-100, 2, 4, 3'b111, 3'b111, "R4");
        step(-100, 2, 4, 3'b111, 3'b011, "R5");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule